// File: doc/BRIEF.md
# Banked Internal Data RAM

This block is the 128-byte scratch RAM inside a small 8-bit controller core. It holds one byte array and gives four views of it. A direct byte access reaches the whole RAM. Direct addresses above the RAM belong to the special-function-register side, so the block only flags them. An indirect byte access reaches the same RAM, and any indirect address above the RAM reads as zero. A register-operand access uses a 3-bit register number, which is placed inside one of four eight-byte banks chosen by two program-status bits. A single-bit access addresses one of 128 bits laid over a sixteen-byte window.

All four views share one read port and one write port. Each access takes one clock. Read data, bit data and the special-register flag are registered and appear one clock after the access. A bit write is a read-modify-write completed in that same clock: it changes only the addressed bit. Read data always shows the contents as they were before any write in the same access.

Top module: `banked_iram`

## Requirements
- R1: A direct access (acc_kind = 0) with address 00h–7Fh writes wr_byte to that byte when acc_wr is high. One clock after the access, rd_byte shows the byte's contents from before the access.
- R2: A direct access with address 80h–FFh sets sfr_hit one clock later, returns rd_byte = 00h and rd_bit = 0, and leaves every RAM byte unchanged.
- R3: An indirect access (acc_kind = 1) with address 00h–7Fh reads and writes the same byte that a direct access to that address reaches.
- R4: An indirect access with address 80h–FFh returns rd_byte = 00h with sfr_hit = 0 and does not write any RAM byte.
- R5: A register access (acc_kind = 2) reaches byte bank_sel×8 + acc_addr[2:0]. Bits acc_addr[7:3] have no effect.
- R6: A new bank_sel value is used by the very next access, with no settling cycle.
- R7: A bit access (acc_kind = 3) with bit address b < 80h reaches bit (b & 7) of byte 20h + (b >> 3). One clock later, rd_bit shows that bit and rd_byte shows the whole byte, both as they were before the access.
- R8: A bit write stores wr_bit into the addressed bit and keeps the other seven bits of that byte.
- R9: A bit access with bit address 80h–FFh sets sfr_hit, returns rd_bit = 0 and rd_byte = 00h, and changes no RAM byte.
- R10: While acc_en is low, rd_byte, rd_bit and sfr_hit hold their last values and the RAM is not written.
- R11: After reset, rd_byte = 00h, rd_bit = 0 and sfr_hit = 0. When the parameter CLEAR_ON_RESET is 1, every RAM byte reads 00h after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Perform an access this clock |
| acc_wr | input | 1 | The access is a write |
| acc_kind | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| acc_addr | input | 8 | Byte address, register number or bit address |
| bank_sel | input | 2 | Active register bank (status word bits 4:3) |
| wr_byte | input | 8 | Byte write data |
| wr_bit | input | 1 | Bit write data |
| rd_byte | output | 8 | Registered byte read data |
| rd_bit | output | 1 | Registered bit read data |
| sfr_hit | output | 1 | Registered flag: the access targeted special-register space |

## Verification
The assertions assume that acc_kind, acc_addr and bank_sel are stable at the sampling edge and that reset is held for at least one clock. They also assume that nothing other than an enabled access changes the array. The bench drives every input on the falling edge, so each rising edge sees settled values. Reset is held for several clocks, and the bench instance sets CLEAR_ON_RESET to 1, so the array starts from a known state.

// File: rtl/iram_pkg.sv
package iram_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int RAM_AW = 7;
    localparam int BPOS_W = 3;

    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'd0,
        ACC_INDIRECT = 2'd1,
        ACC_REGOP    = 2'd2,
        ACC_BITOP    = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              in_ram;
        logic              sfr;
        logic              is_bit;
        logic [RAM_AW-1:0] byte_addr;
        logic [BPOS_W-1:0] bit_pos;
    } target_t;

    typedef struct packed {
        logic [DATA_W-1:0] rd_byte;
        logic              rd_bit;
        logic              sfr_hit;
    } resp_t;
endpackage

// File: rtl/iram_decode.sv
module iram_decode
    import iram_pkg::*;
#(
    parameter int BANKS     = 4,
    parameter int BANK_REGS = 8,
    parameter int RAM_BYTES = 128,
    parameter int BIT_BASE  = 32
) (
    input  acc_kind_e             kind,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [$clog2(BANKS)-1:0] bank,
    output target_t               tgt
);
    localparam int REG_W  = $clog2(BANK_REGS);
    localparam int BANK_W = $clog2(BANKS);
    localparam logic [RAM_AW-1:0] BIT_BASE_A = RAM_AW'(BIT_BASE);

    always_comb begin
        tgt = '0;
        unique case (kind)
            ACC_DIRECT: begin
                if (int'(addr) >= RAM_BYTES) begin
                    tgt.sfr = 1'b1;
                end else begin
                    tgt.in_ram    = 1'b1;
                    tgt.byte_addr = addr[RAM_AW-1:0];
                end
            end
            ACC_INDIRECT: begin
                if (int'(addr) < RAM_BYTES) begin
                    tgt.in_ram    = 1'b1;
                    tgt.byte_addr = addr[RAM_AW-1:0];
                end
            end
            ACC_REGOP: begin
                tgt.in_ram    = 1'b1;
                tgt.byte_addr = RAM_AW'({bank, addr[REG_W-1:0]});
            end
            ACC_BITOP: begin
                if (addr[ADDR_W-1]) begin
                    tgt.sfr = 1'b1;
                end else begin
                    tgt.in_ram    = 1'b1;
                    tgt.is_bit    = 1'b1;
                    tgt.byte_addr = BIT_BASE_A + RAM_AW'(addr[ADDR_W-2:BPOS_W]);
                    tgt.bit_pos   = addr[BPOS_W-1:0];
                end
            end
            default: tgt = '0;
        endcase
    end
endmodule

// File: rtl/iram_bitmask.sv
module iram_bitmask
    import iram_pkg::*;
(
    input  target_t           tgt,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              wr_bit,
    output logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] wval
);
    always_comb begin
        if (tgt.is_bit) begin
            wmask = DATA_W'(1) << tgt.bit_pos;
            wval  = {DATA_W{wr_bit}};
        end else begin
            wmask = '1;
            wval  = wr_byte;
        end
    end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
    parameter int DEPTH          = 128,
    parameter int WIDTH          = 8,
    parameter bit CLEAR_ON_RESET = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wmask,
    input  logic [WIDTH-1:0]         wval,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] row_d;

    always_comb begin
        row_d = (mem_q[waddr] & ~wmask) | (wval & wmask);
        rdata = mem_q[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (CLEAR_ON_RESET) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= row_d;
        end
    end

    assert_unmasked_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem_q[$past(waddr)] ^ $past(mem_q[waddr])) & ~$past(wmask)) == '0);

    assert_masked_bits_written_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem_q[$past(waddr)] ^ $past(wval)) & $past(wmask)) == '0);
endmodule

// File: rtl/banked_iram.sv
module banked_iram
    import iram_pkg::*;
#(
    parameter int BANKS          = 4,
    parameter int BANK_REGS      = 8,
    parameter int RAM_BYTES      = 128,
    parameter int BIT_BASE       = 32,
    parameter int BIT_BYTES      = 16,
    parameter bit CLEAR_ON_RESET = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [1:0]  acc_kind,
    input  logic [7:0]  acc_addr,
    input  logic [1:0]  bank_sel,
    input  logic [7:0]  wr_byte,
    input  logic        wr_bit,
    output logic [7:0]  rd_byte,
    output logic        rd_bit,
    output logic        sfr_hit
);
    localparam int RAM_AW_L = $clog2(RAM_BYTES);
    localparam int REG_SPAN = BANKS * BANK_REGS;

    acc_kind_e         kind;
    target_t           tgt;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] wval;
    logic [DATA_W-1:0] old_byte;
    logic              we;
    resp_t             resp_d, resp_q;

    assign kind = acc_kind_e'(acc_kind);

    iram_decode #(
        .BANKS     (BANKS),
        .BANK_REGS (BANK_REGS),
        .RAM_BYTES (RAM_BYTES),
        .BIT_BASE  (BIT_BASE)
    ) u_decode (
        .kind (kind),
        .addr (acc_addr),
        .bank (bank_sel),
        .tgt  (tgt)
    );

    iram_bitmask u_bitmask (
        .tgt     (tgt),
        .wr_byte (wr_byte),
        .wr_bit  (wr_bit),
        .wmask   (wmask),
        .wval    (wval)
    );

    iram_store #(
        .DEPTH          (RAM_BYTES),
        .WIDTH          (DATA_W),
        .CLEAR_ON_RESET (CLEAR_ON_RESET)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (tgt.byte_addr[RAM_AW_L-1:0]),
        .wmask (wmask),
        .wval  (wval),
        .raddr (tgt.byte_addr[RAM_AW_L-1:0]),
        .rdata (old_byte)
    );

    always_comb begin
        resp_d = resp_q;
        we     = acc_en && acc_wr && tgt.in_ram;
        if (acc_en) begin
            resp_d.rd_byte = tgt.in_ram ? old_byte : '0;
            resp_d.rd_bit  = tgt.in_ram && tgt.is_bit && old_byte[tgt.bit_pos];
            resp_d.sfr_hit = tgt.sfr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rd_byte = resp_q.rd_byte;
    assign rd_bit  = resp_q.rd_bit;
    assign sfr_hit = resp_q.sfr_hit;

    assert_sfr_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_hit |-> (rd_byte == '0 && !rd_bit));

    assert_direct_high_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && kind == ACC_DIRECT && acc_addr[7]) |=> sfr_hit);

    assert_indirect_high_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && kind == ACC_INDIRECT && acc_addr[7]) |-> !we);

    assert_indirect_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && kind == ACC_INDIRECT && acc_addr[7]) |=> (rd_byte == '0 && !sfr_hit));

    assert_regop_in_banks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && kind == ACC_REGOP) |->
            (int'(tgt.byte_addr) < REG_SPAN && tgt.byte_addr[2:0] == acc_addr[2:0]));

    assert_bit_in_area_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && kind == ACC_BITOP && !acc_addr[7]) |->
            (int'(tgt.byte_addr) >= BIT_BASE && int'(tgt.byte_addr) < BIT_BASE + BIT_BYTES
             && $countones(wmask) == 1));

    assert_bit_sfr_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && kind == ACC_BITOP && acc_addr[7]) |-> !we);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> ($stable(rd_byte) && $stable(rd_bit) && $stable(sfr_hit)));
endmodule

// File: tb/banked_iram_bench.sv
`timescale 1ns/1ps
module banked_iram_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_en, acc_wr, wr_bit;
    logic [1:0] acc_kind, bank_sel;
    logic [7:0] acc_addr, wr_byte;
    logic [7:0] rd_byte;
    logic       rd_bit, sfr_hit;

    int n_vec  = 0;
    int n_fail = 0;
    logic [7:0] model [128];
    logic [7:0] last_byte;
    logic       last_bit, last_sfr;

    always #2 clk = ~clk;

    banked_iram #(.CLEAR_ON_RESET(1'b1)) u_banked_iram (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .bank_sel(bank_sel),
        .wr_byte(wr_byte), .wr_bit(wr_bit),
        .rd_byte(rd_byte), .rd_bit(rd_bit), .sfr_hit(sfr_hit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access; expected values derived from the requirement text.
    task automatic access(input logic [1:0] k, input logic [7:0] a, input logic [1:0] b,
                          input logic w, input logic [7:0] wb, input logic wbit,
                          input string req);
        logic in_ram, sfr, isbit;
        logic [6:0] idx;
        logic [2:0] pos;
        logic [7:0] eb;
        logic       ebit;
        in_ram = 0; sfr = 0; isbit = 0; idx = 0; pos = 0;
        case (k)
            2'd0: if (a >= 8'h80) sfr = 1; else begin in_ram = 1; idx = a[6:0]; end
            2'd1: if (a < 8'h80) begin in_ram = 1; idx = a[6:0]; end
            2'd2: begin in_ram = 1; idx = 7'(b * 8 + a % 8); end
            default: if (a >= 8'h80) sfr = 1;
                     else begin in_ram = 1; isbit = 1; idx = 7'(8'h20 + a / 8); pos = 3'(a % 8); end
        endcase
        eb   = in_ram ? model[idx] : 8'h00;
        ebit = isbit ? eb[pos] : 1'b0;
        @(negedge clk);
        acc_en = 1; acc_wr = w; acc_kind = k; acc_addr = a; bank_sel = b;
        wr_byte = wb; wr_bit = wbit;
        @(posedge clk);
        @(negedge clk);
        acc_en = 0;
        check(rd_byte == eb, req, rd_byte, eb);
        check(rd_bit == ebit, req, rd_bit, ebit);
        check(sfr_hit == sfr, req, sfr_hit, sfr);
        if (w && in_ram) begin
            if (isbit) model[idx][pos] = wbit;
            else       model[idx] = wb;
        end
        last_byte = eb; last_bit = ebit; last_sfr = sfr;
    endtask

    task automatic verify_ram(input string req);
        for (int i = 0; i < 128; i++) access(2'd0, 8'(i), 2'd0, 1'b0, 8'h00, 1'b0, req);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        rst_n = 0; acc_en = 0; acc_wr = 0; acc_kind = 0; acc_addr = 0;
        bank_sel = 0; wr_byte = 0; wr_bit = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state of outputs and array
        check(rd_byte == 8'h00, "R11", rd_byte, 0);
        check(rd_bit == 1'b0, "R11", rd_bit, 0);
        check(sfr_hit == 1'b0, "R11", sfr_hit, 0);
        verify_ram("R11");

        // R1 direct writes over the whole RAM, R3 indirect read back
        for (int i = 0; i < 128; i++)
            access(2'd0, 8'(i), 2'd0, 1'b1, 8'((i * 37 + 11) ^ 8'h5A), 1'b0, "R1");
        for (int i = 0; i < 128; i++) access(2'd1, 8'(i), 2'd0, 1'b0, 8'h00, 1'b0, "R3");
        for (int i = 0; i < 128; i += 3)
            access(2'd1, 8'(i), 2'd0, 1'b1, 8'(i ^ 8'hC3), 1'b0, "R3");
        verify_ram("R3");

        // R2 direct special-register space: flagged, RAM untouched
        for (int i = 128; i < 256; i++) access(2'd0, 8'(i), 2'd0, 1'b1, 8'hFF, 1'b0, "R2");
        verify_ram("R2");

        // R4 indirect above RAM: zero, no flag, no write
        for (int i = 128; i < 256; i++) access(2'd1, 8'(i), 2'd0, 1'b1, 8'hEE, 1'b0, "R4");
        verify_ram("R4");

        // R5 register operands, upper number bits varied
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 8; n++)
                access(2'd2, 8'((b * 53 + n * 8) % 32 * 8 + n), 2'(b), 1'b1,
                       8'(b * 16 + n + 8'h90), 1'b0, "R5");
        for (int i = 0; i < 32; i++) access(2'd2, 8'(8'hF8 + i % 8), 2'(i / 8), 1'b0, 8'h00, 1'b0, "R5");
        verify_ram("R5");

        // R6 bank switched on every consecutive access
        for (int i = 0; i < 32; i++) access(2'd2, 8'd3, 2'(i % 4), 1'b0, 8'h00, 1'b0, "R6");
        for (int i = 0; i < 16; i++) access(2'd2, 8'(i % 8), 2'((i * 3) % 4), 1'b1, 8'(i + 8'h40), 1'b0, "R6");
        verify_ram("R6");

        // R7/R8 bit writes over all 128 bits, then bit reads and byte checks
        for (int bt = 0; bt < 128; bt++)
            access(2'd3, 8'(bt), 2'd0, 1'b1, 8'hA5, 1'((bt * 7 + bt / 5) % 2), "R8");
        for (int bt = 0; bt < 128; bt++) access(2'd3, 8'(bt), 2'd0, 1'b0, 8'h00, 1'b0, "R7");
        for (int bt = 0; bt < 128; bt += 9)
            access(2'd3, 8'(bt), 2'd0, 1'b1, 8'h00, ~model[8'h20 + bt / 8][bt % 8], "R8");
        verify_ram("R8");

        // R9 bit space above the RAM window
        for (int bt = 128; bt < 256; bt++) access(2'd3, 8'(bt), 2'd0, 1'b1, 8'h00, 1'b1, "R9");
        verify_ram("R9");

        // R10 outputs and RAM hold while idle
        access(2'd0, 8'h23, 2'd0, 1'b0, 8'h00, 1'b0, "R10");
        @(negedge clk);
        acc_wr = 1; acc_kind = 2'd0; acc_addr = 8'h23; wr_byte = ~model[8'h23];
        repeat (3) begin
            @(negedge clk);
            check(rd_byte == last_byte, "R10", rd_byte, last_byte);
            check(rd_bit == last_bit, "R10", rd_bit, last_bit);
            check(sfr_hit == last_sfr, "R10", sfr_hit, last_sfr);
        end
        acc_wr = 0;
        access(2'd0, 8'h23, 2'd0, 1'b0, 8'h00, 1'b0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule